// File: doc/BRIEF.md
# Small-Page NAND Read Sequencer

This block turns a host request, a linear byte address and a byte count, into the read sequence of an 8-bit small-page NAND flash device. A page holds 512 main-area bytes. The linear address is split into a 9-bit byte position within the page and a page index. Bit 8 of the position is not sent on the bus. It is carried by the choice of read opcode, which selects the lower or upper half of the page. The low eight position bits go out in the first address cycle, and the page index goes out in the next three.

After the address phase the sequencer waits a fixed settling window and then watches the ready/busy line through a two-flop synchroniser. Once the line shows ready, it pulses the read strobe once per byte and hands each byte to the host as a one-cycle valid pulse. When it reaches the last main-area byte of a page it releases chip enable. It then reopens the device at position 0 of the following page. The whole sequence repeats until the requested count has been delivered, and the block then signals completion.

The IO pins are split into an output value, an output enable and an input value, so that the pad buffer can sit outside the block. Every bus strobe is generated from programmable low and high cycle counts.

Top module: `nand_sp_reader`

## Requirements
- R1: The byte position within the page is `start_addr[8:0]` and the page index is `start_addr >> 9`. The first address cycle carries position bits [7:0] only, so position bit 8 never appears on IO.
- R2: The opcode written in the command cycle of the first page is 8'h01 when position bit 8 is set and 8'h00 otherwise. During the command cycle CLE is high and ALE is low.
- R3: Exactly four address cycles follow each command. They carry, in this order, position [7:0], page [7:0], page [15:8] and page [23:16], with page bits above the index width sent as zero. During address cycles ALE is high and CLE is low.
- R4: For each bus write, the block drives IO (output enable high) with a stable value while WE# is low. WE# stays low for exactly `STB_LO` cycles and rises to latch the value. CLE and ALE are never high together, and WE# and RE# are never low together.
- R5: After the fourth address cycle the block waits at least `TWB_CYC` cycles and then waits for the synchronised R/B# to be high. RE# never falls while R/B# is low.
- R6: Bytes are read one per RE# pulse. Each byte is the IO input value at the end of the RE# low phase. The bytes arrive in linear address order, each with a one-cycle `dout_valid` pulse.
- R7: When position 511 of a page has been read and bytes remain, the next page is opened at position 0. It gets a fresh sequence with opcode 8'h00, a first address byte of 8'h00 and the page index plus one. There is one command sequence per page touched.
- R8: CE# goes low before each page's command and returns high after that page's last byte, so there is one CE# release per page touched. WE# and RE# only go low while CE# is low. CE# is high whenever the block is idle.
- R9: The stream stops after exactly `start_len` bytes, even in mid-page. `done` pulses for one cycle and `busy` is low at that point. A start with `start_len` = 0 pulses `done` with no bus activity.
- R10: A `start` pulse while `busy` is high is ignored, and the running transfer continues unchanged.
- R11: After reset: CE#, WE# and RE# are high; CLE, ALE, output enable, `busy`, `done` and `dout_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| start_addr | input | ADDR_W | Linear byte address of the first byte |
| start_len | input | LEN_W | Number of bytes to deliver |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |
| dout | output | 8 | Delivered byte |
| dout_valid | output | 1 | `dout` holds a new byte this cycle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready (high) / busy (low) from the device |
| nand_io_o | output | 8 | IO value to drive |
| nand_io_oe | output | 1 | IO output enable |
| nand_io_i | input | 8 | IO value from the pad |

## Verification
The bench builds the block with a 26-bit address, a 16-bit count, a two-cycle strobe low phase, a one-cycle high phase (the shortest allowed) and a four-cycle settling window. It pairs this with a device model that stays busy for 25 cycles. With this configuration, requests of up to 700 bytes cross one or two page boundaries in a few thousand cycles. Addresses near the top of the space drive page bit 16 into the fourth address cycle. Starts at positions 255 and 511 exercise the half-page opcode boundary and the page wrap.

// File: rtl/nsr_pkg.sv
`timescale 1ns/1ps
package nsr_pkg;
  localparam int COL_W = 9;
  localparam logic [COL_W-1:0] COL_LAST = 9'd511;
  localparam logic [7:0] OP_READ_LO = 8'h00;
  localparam logic [7:0] OP_READ_HI = 8'h01;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_OPEN, SQ_CMD, SQ_ADDR, SQ_SETTLE, SQ_WAIT, SQ_READ, SQ_NEXT
  } seq_st_t;

  typedef enum logic [1:0] {
    PH_IDLE, PH_LOW, PH_HIGH
  } strobe_ph_t;
endpackage

// File: rtl/nsr_addr_split.sv
`timescale 1ns/1ps
module nsr_addr_split #(
  parameter int PAGE_W = 17
) (
  input  logic [nsr_pkg::COL_W-1:0] col,
  input  logic [PAGE_W-1:0]         page,
  output logic [7:0]                cmd_byte,
  output logic [3:0][7:0]           addr_bytes
);
  import nsr_pkg::*;

  logic [23:0] page_ext;

  always_comb begin
    page_ext = '0;
    page_ext[PAGE_W-1:0] = page;
  end

  // half-page selection travels in the opcode, not on IO
  assign cmd_byte      = col[8] ? OP_READ_HI : OP_READ_LO;
  assign addr_bytes[0] = col[7:0];

  for (genvar g = 1; g < 4; g++) begin : g_page_byte
    assign addr_bytes[g] = page_ext[8*(g-1) +: 8];
  end
endmodule

// File: rtl/nsr_strobe.sv
`timescale 1ns/1ps
module nsr_strobe #(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       is_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] io_i,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_o,
  output logic       io_oe,
  output logic [7:0] rdata,
  output logic       fin
);
  import nsr_pkg::*;

  localparam int CNT_MAX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  strobe_ph_t    ph;
  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      rd_q  <= 1'b0;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      io_o  <= '0;
      io_oe <= 1'b0;
      rdata <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          rd_q <= is_rd;
          cnt  <= CW'(LO_CYC - 1);
          ph   <= PH_LOW;
          if (is_rd) begin
            re_n <= 1'b0;
          end else begin
            we_n  <= 1'b0;
            io_oe <= 1'b1;
            io_o  <= wdata;
          end
        end
        PH_LOW: if (cnt == '0) begin
          we_n <= 1'b1;
          re_n <= 1'b1;
          if (rd_q) rdata <= io_i;
          cnt <= CW'(HI_CYC - 1);
          ph  <= PH_HIGH;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_HIGH: if (cnt == '0) begin
          fin   <= 1'b1;
          io_oe <= 1'b0;
          ph    <= PH_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_sp_reader.sv
`timescale 1ns/1ps
module nand_sp_reader #(
  parameter int ADDR_W  = 26,
  parameter int LEN_W   = 16,
  parameter int STB_LO  = 2,
  parameter int STB_HI  = 2,
  parameter int TWB_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic [7:0]        dout,
  output logic              dout_valid,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  input  logic              nand_rb_n,
  output logic [7:0]        nand_io_o,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_i
);
  import nsr_pkg::*;

  localparam int PAGE_W = ADDR_W - COL_W;
  localparam int TW     = $clog2(TWB_CYC + 1);

  seq_st_t           st;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic [LEN_W-1:0]  remain;
  logic [1:0]        idx;
  logic [TW-1:0]     wcnt;
  logic              go, go_rd;
  logic [7:0]        wbyte;
  logic              rb_q1, rb_q2;
  logic [7:0]        cmd_byte;
  logic [3:0][7:0]   addr_bytes;
  logic [7:0]        rdata;
  logic              fin;

  nsr_addr_split #(.PAGE_W(PAGE_W)) u_split (
    .col(col), .page(page), .cmd_byte(cmd_byte), .addr_bytes(addr_bytes)
  );

  nsr_strobe #(.LO_CYC(STB_LO), .HI_CYC(STB_HI)) u_strobe (
    .clk(clk), .rst(rst), .go(go), .is_rd(go_rd), .wdata(wbyte),
    .io_i(nand_io_i), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_o(nand_io_o), .io_oe(nand_io_oe), .rdata(rdata), .fin(fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_q1 <= 1'b1;
      rb_q2 <= 1'b1;
    end else begin
      rb_q1 <= nand_rb_n;
      rb_q2 <= rb_q1;
    end
  end

  assign busy = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      col        <= '0;
      page       <= '0;
      remain     <= '0;
      idx        <= '0;
      wcnt       <= '0;
      go         <= 1'b0;
      go_rd      <= 1'b0;
      wbyte      <= '0;
      nand_ce_n  <= 1'b1;
      nand_cle   <= 1'b0;
      nand_ale   <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      go         <= 1'b0;
      dout_valid <= 1'b0;
      done       <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          if (start_len == '0) begin
            done <= 1'b1;
          end else begin
            col       <= start_addr[COL_W-1:0];
            page      <= PAGE_W'(start_addr >> COL_W);
            remain    <= start_len;
            nand_ce_n <= 1'b0;
            st        <= SQ_OPEN;
          end
        end
        SQ_OPEN: begin
          nand_cle <= 1'b1;
          wbyte    <= cmd_byte;
          go       <= 1'b1;
          go_rd    <= 1'b0;
          st       <= SQ_CMD;
        end
        SQ_CMD: if (fin) begin
          nand_cle <= 1'b0;
          nand_ale <= 1'b1;
          idx      <= 2'd0;
          wbyte    <= addr_bytes[0];
          go       <= 1'b1;
          st       <= SQ_ADDR;
        end
        SQ_ADDR: if (fin) begin
          if (idx == 2'd3) begin
            nand_ale <= 1'b0;
            wcnt     <= TW'(TWB_CYC - 1);
            st       <= SQ_SETTLE;
          end else begin
            idx   <= idx + 2'd1;
            wbyte <= addr_bytes[idx + 2'd1];
            go    <= 1'b1;
          end
        end
        SQ_SETTLE: if (wcnt == '0) st <= SQ_WAIT;
                   else wcnt <= wcnt - 1'b1;
        SQ_WAIT: if (rb_q2) begin
          go    <= 1'b1;
          go_rd <= 1'b1;
          st    <= SQ_READ;
        end
        SQ_READ: if (fin) begin
          dout       <= rdata;
          dout_valid <= 1'b1;
          remain     <= remain - 1'b1;
          if (remain == LEN_W'(1)) begin
            nand_ce_n <= 1'b1;
            done      <= 1'b1;
            st        <= SQ_IDLE;
          end else if (col == COL_LAST) begin
            nand_ce_n <= 1'b1;
            col       <= '0;
            page      <= page + 1'b1;
            st        <= SQ_NEXT;
          end else begin
            col   <= col + 1'b1;
            go    <= 1'b1;
            go_rd <= 1'b1;
          end
        end
        SQ_NEXT: begin
          nand_ce_n <= 1'b0;
          st        <= SQ_OPEN;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nsr_chk.sv
`timescale 1ns/1ps
module nsr_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       dout_valid,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_rb_n,
  input logic [7:0] nand_io_o,
  input logic       nand_io_oe
);
  // R4
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  // R4
  we_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_io_oe);
  // R4
  we_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_io_o));
  // R8
  strobe_ce_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  // R5
  re_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nand_re_n) |-> nand_rb_n);
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> !dout_valid);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && nand_ce_n));
  // R8
  idle_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> nand_ce_n);
endmodule

bind nand_sp_reader nsr_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .dout_valid(dout_valid),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n),
  .nand_io_o(nand_io_o), .nand_io_oe(nand_io_oe)
);

// File: tb/nand_sp_reader_tb.sv
`timescale 1ns/1ps
module nand_sp_reader_tb;
  localparam int ADDR_W = 26;
  localparam int LEN_W  = 16;
  localparam int LO     = 2;
  localparam int HI     = 1;
  localparam int TWB    = 4;
  localparam int BUSY   = 25;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [LEN_W-1:0]  start_len = '0;
  logic busy, done, dout_valid, ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0] dout, io_o, io_i;
  logic rb_n = 1'b1;

  nand_sp_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STB_LO(LO), .STB_HI(HI),
                   .TWB_CYC(TWB)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .dout(dout),
    .dout_valid(dout_valid), .nand_ce_n(ce_n), .nand_cle(cle),
    .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_rb_n(rb_n),
    .nand_io_o(io_o), .nand_io_oe(io_oe), .nand_io_i(io_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [16:0] pg, input logic [8:0] c);
    return c[7:0] + pg[7:0] * 8'd29 + pg[15:8] * 8'd7 +
           (pg[16] ? 8'd91 : 8'd0) + (c[8] ? 8'hA5 : 8'h00);
  endfunction

  // device model
  logic       p_we = 1'b1, p_re = 1'b1, p_ce = 1'b1;
  logic [7:0] m_cmd = '0;
  logic [7:0] ab [4];
  logic [7:0] f_ab [4];
  logic [7:0] f_cmd = '0;
  int         aidx = 0, busy_cnt = 0, lo_cnt = 0;
  logic [16:0] m_page = '0;
  logic [8:0]  m_col = '0;
  int  cmd_cnt = 0, ce_rise = 0, later_bad = 0;
  int  v_wr = 0, v_busy = 0, v_ce = 0;
  bit  f_got = 1'b0;

  assign io_i = (!ce_n && !re_n) ? pat(m_page, m_col) : 8'h00;

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (!p_ce && ce_n) ce_rise++;
    if (!we_n) lo_cnt++;
    if (p_we && !we_n && ce_n) v_ce++;
    if (p_re && !re_n && ce_n) v_ce++;
    if (p_re && !re_n && busy_cnt > 0) v_busy++;
    if (!p_we && we_n) begin
      if (lo_cnt != LO || !io_oe) v_wr++;
      lo_cnt = 0;
      if (cle && !ale) begin
        m_cmd = io_o; aidx = 0; cmd_cnt++;
        if (!f_got) f_cmd = io_o;
        else if (io_o != 8'h00) later_bad++;
      end else if (ale && !cle && aidx < 4) begin
        ab[aidx] = io_o;
        if (!f_got) f_ab[aidx] = io_o;
        else if (aidx == 0 && io_o != 8'h00) later_bad++;
        aidx++;
        if (aidx == 4) begin
          m_col  = {m_cmd == 8'h01, ab[0]};
          m_page = {ab[3][0], ab[2], ab[1]};
          if (ab[3][7:1] != 7'd0) v_wr++;
          busy_cnt = BUSY;
          f_got = 1'b1;
        end
      end else begin
        v_wr++;
      end
    end
    if (!p_re && re_n) m_col = m_col + 9'd1;
    p_we = we_n; p_re = re_n; p_ce = ce_n;
    rb_n = (busy_cnt == 0);
  end

  // output collector
  logic [ADDR_W-1:0] cur_addr = '0;
  int  got = 0, mism = 0;
  logic [7:0] m_act = '0, m_exp = '0;
  bit  done_seen = 1'b0;

  always @(negedge clk) begin
    logic [ADDR_W-1:0] a;
    logic [7:0] e;
    if (dout_valid) begin
      a = cur_addr + ADDR_W'(got);
      e = pat(a[25:9], a[8:0]);
      if (dout !== e) begin
        if (mism == 0) begin m_act = dout; m_exp = e; end
        mism++;
      end
      got++;
    end
    if (done) done_seen = 1'b1;
  end

  task automatic run(input logic [ADDR_W-1:0] addr, input int len, input bit inject);
    int wd;
    int pages;
    cur_addr = addr; got = 0; mism = 0; done_seen = 1'b0;
    cmd_cnt = 0; ce_rise = 0; f_got = 1'b0; later_bad = 0;
    @(negedge clk);
    start = 1'b1; start_addr = addr; start_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    wd = 0;
    while (!done_seen && wd < 40000) begin
      @(negedge clk);
      wd++;
      if (inject && wd == 30) begin
        start = 1'b1; start_addr = '0; start_len = 16'd5;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    @(negedge clk);
    pages = (len == 0) ? 0 : ((int'(addr[8:0]) + len - 1) / 512 + 1);
    chk(done_seen, "R9", "done pulse seen", done_seen, 1);
    chk(got == len, "R9", "bytes delivered", got, len);
    chk(ce_n && !busy, "R8", "CE# high and idle after done", {ce_n, busy}, 2'b10);
    if (len == 0) begin
      chk(cmd_cnt == 0 && ce_rise == 0, "R9", "no bus activity for zero length",
          cmd_cnt + ce_rise, 0);
    end else begin
      chk(mism == 0, "R6", "byte stream", m_act, m_exp);
      chk(f_cmd == (addr[8] ? 8'h01 : 8'h00), "R2", "half-page opcode",
          f_cmd, addr[8] ? 8'h01 : 8'h00);
      chk(f_ab[0] == addr[7:0], "R1", "first address byte", f_ab[0], addr[7:0]);
      chk({f_ab[3], f_ab[2], f_ab[1]} == 24'(addr >> 9), "R3", "page address bytes",
          {f_ab[3], f_ab[2], f_ab[1]}, 24'(addr >> 9));
      chk(cmd_cnt == pages, "R7", "command sequences", cmd_cnt, pages);
      chk(later_bad == 0, "R7", "later pages open at position 0 with 00h", later_bad, 0);
      chk(ce_rise == pages, "R8", "CE# releases", ce_rise, pages);
      if (inject)
        chk(mism == 0 && got == len, "R10", "start while busy ignored", got, len);
    end
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    chk(ce_n && we_n && re_n, "R11", "strobes high in reset", {ce_n, we_n, re_n}, 3'b111);
    chk(!cle && !ale && !io_oe, "R11", "latch enables low in reset", {cle, ale, io_oe}, 0);
    chk(!busy && !done && !dout_valid, "R11", "status low in reset",
        {busy, done, dout_valid}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run(26'd0, 3, 1'b0);
    run(26'd5000, 130, 1'b0);
    run(26'd255, 2, 1'b0);
    run(26'd511, 3, 1'b0);
    run(26'h3FFFF00, 2, 1'b0);
    run(26'd77, 0, 1'b0);
    run(26'd1000, 300, 1'b1);
    for (int k = 0; k < 8; k++) begin
      logic [ADDR_W-1:0] ra;
      int rl;
      ra = ADDR_W'($urandom);
      rl = 1 + int'($urandom % 700);
      run(ra, rl, 1'b0);
    end
    chk(v_wr == 0, "R4", "write strobe width, drive and address byte padding", v_wr, 0);
    chk(v_busy == 0, "R5", "RE# fell while device busy", v_busy, 0);
    chk(v_ce == 0, "R8", "strobe with CE# high", v_ce, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule